// File: doc/BRIEF.md
# Power-Management Event and Timer Registers

This block is the core of a power-management I/O function. It holds three 16-bit registers: an event status register whose bits are cleared by writing 1, an event enable register, and a control register. Beside them runs a free-running power-management timer that software reads as 24 bits. All of them are reached through a byte-addressed port on which only the low six address bits are decoded. The block drives a level-sensitive system control interrupt (SCI). That output is high while any of four event sources is both flagged and enabled: timer, global lock, power button and real-time clock.

A control write with the sleep-enable bit set is handed to a small sequencer with three states, `SLP_IDLE`, `SLP_OFF` and `SLP_WAKE`. From any state, such a write moves the sequencer to `SLP_OFF` when the sleep type is 0 and to `SLP_WAKE` when it is 1. Any other sleep type, or no such write, returns it to `SLP_IDLE`. In `SLP_OFF` the block emits a one-cycle shutdown request. In `SLP_WAKE` it emits a one-cycle reset request together with a resume marker, after wake and power-button status were set on the write edge.

Writes from the firmware power-management command port can turn SCI mode on or off in the control register. They can also produce a one-cycle SMI pulse. An external power-button event sets its status bit only while the matching enable bit is set. The timer advances on a tick-enable input. Its status flag is raised when the count reaches a stored boundary. Clearing that flag moves the boundary to the next multiple of 2^OVF_SHIFT.

Top module: `pm_evt_regs`

## Requirements
- R1: Only bus_addr[5:0] is decoded. A 16-bit read (bus_size32=0) returns status at offset 0x00, enable at 0x02 and control at 0x04. A 32-bit read (bus_size32=1) at offset 0x08 returns the timer. Every other read returns 0, and 32-bit writes have no effect.
- R2: A 16-bit write at offset 0x02 loads the enable register, which reads back unchanged.
- R3: A 16-bit write at offset 0x00 clears each status bit written as 1 and leaves bits written as 0 unchanged.
- R4: The timer count increments on each clock with tick_en high. A 32-bit read returns its low TMR_W bits zero-extended, and that value wraps at 2^TMR_W.
- R5: Status bit 0 (timer) becomes 1 on the clock after the count reaches the overflow boundary, which is 2^OVF_SHIFT after reset.
- R6: A status write that clears a set timer status bit reloads the boundary with (count + 2^OVF_SHIFT) rounded down to a multiple of 2^OVF_SHIFT.
- R7: sci_irq is 1 exactly when (status AND enable) has any of bits 0, 5, 8 or 10 set. Wake status (bit 15) never drives it.
- R8: A 16-bit write at offset 0x04 stores the value with bit 13 (sleep enable) forced to 0.
- R9: A control write with bit 13 set and bits 12:10 equal to 0 makes shutdown_req high for exactly the next clock cycle.
- R10: A control write with bit 13 set and bits 12:10 equal to 1 sets status bits 15 and 8, and drives reset_req and s3_mark high for the next clock cycle. Other sleep types produce no pulse and no status change.
- R11: apm_wr with apm_data 0xF1 sets control bit 0, with 0xF0 clears it, and with any other value leaves the control register unchanged.
- R12: smi_pulse is high for one cycle, on the cycle after an apm_wr seen while smi_en is high, and is low otherwise.
- R13: pwrbtn_evt sets status bit 8 only while enable bit 8 is 1.
- R14: After reset all three registers and the timer read 0, and sci_irq, shutdown_req, reset_req, s3_mark and smi_pulse are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Port write strobe |
| bus_rd | input | 1 | Port read strobe |
| bus_size32 | input | 1 | 1 for a 32-bit access, 0 for a 16-bit access |
| bus_addr | input | ADDR_W | Port address; low 6 bits decoded |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| tick_en | input | 1 | Advances the timer by one |
| pwrbtn_evt | input | 1 | Power-button event |
| apm_wr | input | 1 | Firmware command byte strobe |
| apm_data | input | 8 | Firmware command byte |
| smi_en | input | 1 | Allows SMI pulses on command writes |
| sci_irq | output | 1 | Level interrupt |
| shutdown_req | output | 1 | One-cycle soft power-off request |
| reset_req | output | 1 | One-cycle system reset request |
| s3_mark | output | 1 | One-cycle resume-from-suspend marker |
| smi_pulse | output | 1 | One-cycle SMI |

## Verification
The bench builds the block with TMR_W=8, CNT_W=16 and OVF_SHIFT=7. With these values the first overflow boundary is 128 ticks away and the re-armed one is at 256. The bench can therefore drive the timer across a boundary, clear the flag, and watch the re-armed boundary trip within a few hundred cycles. At 256 the 8-bit timer read also wraps to zero, so the zero-extended wrap is checked at the same moment as the second boundary.

// File: rtl/pm_evt_pkg.sv
package pm_evt_pkg;
    // status / enable bit positions
    localparam int TMR_BIT    = 0;
    localparam int GLBL_BIT   = 5;
    localparam int PWRBTN_BIT = 8;
    localparam int RTC_BIT    = 10;
    localparam int WAKE_BIT   = 15;
    // control bit positions
    localparam int SCIEN_BIT  = 0;
    localparam int SLPEN_BIT  = 13;
    localparam int SLPTYP_LO  = 10;
    localparam int SLPTYP_W   = 3;

    localparam logic [15:0] SCI_SRC_MASK =
        16'((1 << TMR_BIT) | (1 << GLBL_BIT) | (1 << PWRBTN_BIT) | (1 << RTC_BIT));

    localparam int          OFS_W   = 6;
    localparam logic [5:0]  OFS_STS = 6'h00;
    localparam logic [5:0]  OFS_EN  = 6'h02;
    localparam logic [5:0]  OFS_CTL = 6'h04;
    localparam logic [5:0]  OFS_TMR = 6'h08;

    localparam logic [7:0]  CMD_SCI_ON  = 8'hF1;
    localparam logic [7:0]  CMD_SCI_OFF = 8'hF0;

    typedef enum logic [1:0] {
        SLP_IDLE = 2'd0,
        SLP_OFF  = 2'd1,
        SLP_WAKE = 2'd2
    } slp_state_e;
endpackage

// File: rtl/pm_tick_timer.sv
module pm_tick_timer #(
    parameter int CNT_W     = 32,
    parameter int OVF_SHIFT = 23
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             rearm,
    output logic [CNT_W-1:0] cnt,
    output logic             hit
);
    localparam logic [CNT_W-1:0] STEP  = {{(CNT_W-1){1'b0}}, 1'b1} << OVF_SHIFT;
    localparam logic [CNT_W-1:0] ALIGN = ~(STEP - 1'b1);

    logic [CNT_W-1:0] bound_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            bound_q <= STEP;
        end else begin
            if (tick_en)
                cnt <= cnt + 1'b1;
            if (rearm)
                bound_q <= (cnt + STEP) & ALIGN;
        end
    end

    assign hit = (cnt >= bound_q);
endmodule

// File: rtl/pm_sleep_fsm.sv
module pm_sleep_fsm
    import pm_evt_pkg::*;
#(
    parameter int TYP_W = SLPTYP_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [TYP_W-1:0] typ,
    output logic             off_req,
    output logic             wake_req
);
    slp_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= SLP_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = SLP_IDLE;
        unique case (state_q)
            SLP_IDLE, SLP_OFF, SLP_WAKE: begin
                if (go && typ == TYP_W'(0))
                    state_d = SLP_OFF;
                else if (go && typ == TYP_W'(1))
                    state_d = SLP_WAKE;
            end
            default: state_d = SLP_IDLE;
        endcase
    end

    always_comb begin
        off_req  = (state_q == SLP_OFF);
        wake_req = (state_q == SLP_WAKE);
    end
endmodule

// File: rtl/pm_evt_regs.sv
module pm_evt_regs
    import pm_evt_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int TMR_W     = 24,
    parameter int CNT_W     = 32,
    parameter int OVF_SHIFT = 23
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic              bus_size32,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [15:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              tick_en,
    input  logic              pwrbtn_evt,
    input  logic              apm_wr,
    input  logic [7:0]        apm_data,
    input  logic              smi_en,
    output logic              sci_irq,
    output logic              shutdown_req,
    output logic              reset_req,
    output logic              s3_mark,
    output logic              smi_pulse
);
    localparam int PAD_W = 32 - TMR_W;

    logic [OFS_W-1:0] ofs;
    logic             unused_addr_hi;
    logic [15:0]      sts_q, en_q, ctl_q;
    logic [15:0]      sts_set, sts_clr, ctl_d;
    logic             wr16, sts_wr, en_wr, ctl_wr;
    logic             slp_go, tmr_rearm, tmr_hit, wake_req;
    logic [SLPTYP_W-1:0] slp_typ;
    logic [CNT_W-1:0] tmr_cnt;

    assign ofs            = bus_addr[OFS_W-1:0];
    assign unused_addr_hi = ^bus_addr[ADDR_W-1:OFS_W];
    assign wr16    = bus_wr && !bus_size32;
    assign sts_wr  = wr16 && (ofs == OFS_STS);
    assign en_wr   = wr16 && (ofs == OFS_EN);
    assign ctl_wr  = wr16 && (ofs == OFS_CTL);
    assign slp_go  = ctl_wr && bus_wdata[SLPEN_BIT];
    assign slp_typ = bus_wdata[SLPTYP_LO +: SLPTYP_W];

    assign tmr_rearm = sts_wr && bus_wdata[TMR_BIT] && (sts_q[TMR_BIT] || tmr_hit);

    pm_tick_timer #(.CNT_W(CNT_W), .OVF_SHIFT(OVF_SHIFT)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .rearm   (tmr_rearm),
        .cnt     (tmr_cnt),
        .hit     (tmr_hit)
    );

    pm_sleep_fsm #(.TYP_W(SLPTYP_W)) u_sleep (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (slp_go),
        .typ      (slp_typ),
        .off_req  (shutdown_req),
        .wake_req (wake_req)
    );

    assign reset_req = wake_req;
    assign s3_mark   = wake_req;

    // status set / clear sources
    always_comb begin
        sts_set = '0;
        sts_set[TMR_BIT]    = tmr_hit;
        sts_set[PWRBTN_BIT] = pwrbtn_evt && en_q[PWRBTN_BIT];
        if (slp_go && slp_typ == SLPTYP_W'(1)) begin
            sts_set[WAKE_BIT]   = 1'b1;
            sts_set[PWRBTN_BIT] = 1'b1;
        end
        sts_clr = sts_wr ? bus_wdata : 16'h0000;
    end

    // control next value: bus write first, firmware command on top
    always_comb begin
        ctl_d = ctl_q;
        if (ctl_wr) begin
            ctl_d = bus_wdata;
            ctl_d[SLPEN_BIT] = 1'b0;
        end
        if (apm_wr && apm_data == CMD_SCI_ON)
            ctl_d[SCIEN_BIT] = 1'b1;
        else if (apm_wr && apm_data == CMD_SCI_OFF)
            ctl_d[SCIEN_BIT] = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sts_q     <= '0;
            en_q      <= '0;
            ctl_q     <= '0;
            smi_pulse <= 1'b0;
        end else begin
            sts_q     <= (sts_q | sts_set) & ~sts_clr;
            if (en_wr)
                en_q <= bus_wdata;
            ctl_q     <= ctl_d;
            smi_pulse <= apm_wr && smi_en;
        end
    end

    assign sci_irq = |(sts_q & en_q & SCI_SRC_MASK);

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            if (!bus_size32) begin
                case (ofs)
                    OFS_STS: bus_rdata = {16'h0000, sts_q};
                    OFS_EN:  bus_rdata = {16'h0000, en_q};
                    OFS_CTL: bus_rdata = {16'h0000, ctl_q};
                    default: bus_rdata = '0;
                endcase
            end else if (ofs == OFS_TMR) begin
                bus_rdata = {{PAD_W{1'b0}}, tmr_cnt[TMR_W-1:0]};
            end
        end
    end
endmodule

// File: rtl/pm_evt_regs_chk.sv
module pm_evt_regs_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_wr,
    input logic             bus_size32,
    input logic [5:0]       ofs,
    input logic             wd_slpen,
    input logic [2:0]       wd_typ,
    input logic             wd_pb,
    input logic             apm_wr,
    input logic             smi_en,
    input logic             tick_en,
    input logic             shutdown_req,
    input logic             reset_req,
    input logic             smi_pulse,
    input logic             sts_pb,
    input logic             sts_wake,
    input logic [CNT_W-1:0] cnt
);
    logic ctl_wr16, sts_wr16;
    assign ctl_wr16 = bus_wr && !bus_size32 && ofs == 6'h04;
    assign sts_wr16 = bus_wr && !bus_size32 && ofs == 6'h00;

    // R9
    off_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr16 && wd_slpen && wd_typ == 3'd0) |=> shutdown_req);

    // R9
    off_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown_req |=> !shutdown_req);

    // R10
    wake_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr16 && wd_slpen && wd_typ == 3'd1) |=> (reset_req && sts_wake && sts_pb));

    // R12
    smi_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        smi_pulse |-> $past(apm_wr && smi_en));

    // R4
    tick_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_en |=> cnt == $past(cnt) + 1'b1);

    // R3
    pb_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_pb && !(sts_wr16 && wd_pb)) |=> sts_pb);
endmodule

bind pm_evt_regs pm_evt_regs_chk #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_wr       (bus_wr),
    .bus_size32   (bus_size32),
    .ofs          (bus_addr[5:0]),
    .wd_slpen     (bus_wdata[13]),
    .wd_typ       (bus_wdata[12:10]),
    .wd_pb        (bus_wdata[8]),
    .apm_wr       (apm_wr),
    .smi_en       (smi_en),
    .tick_en      (tick_en),
    .shutdown_req (shutdown_req),
    .reset_req    (reset_req),
    .smi_pulse    (smi_pulse),
    .sts_pb       (sts_q[8]),
    .sts_wake     (sts_q[15]),
    .cnt          (tmr_cnt)
);

// File: tb/test_pm_evt_regs.sv
module test_pm_evt_regs;
    localparam int ADDR_W = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_wr = 1'b0, bus_rd = 1'b0, bus_size32 = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [15:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              tick_en = 1'b0, pwrbtn_evt = 1'b0;
    logic              apm_wr = 1'b0, smi_en = 1'b0;
    logic [7:0]        apm_data = '0;
    logic              sci_irq, shutdown_req, reset_req, s3_mark, smi_pulse;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] rv;

    always #4 clk = ~clk;

    pm_evt_regs #(.ADDR_W(ADDR_W), .TMR_W(8), .CNT_W(16), .OVF_SHIFT(7)) i_pm_evt_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_size32(bus_size32), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .tick_en(tick_en), .pwrbtn_evt(pwrbtn_evt),
        .apm_wr(apm_wr), .apm_data(apm_data), .smi_en(smi_en),
        .sci_irq(sci_irq), .shutdown_req(shutdown_req), .reset_req(reset_req),
        .s3_mark(s3_mark), .smi_pulse(smi_pulse)
    );

    typedef struct packed {
        logic        wr;
        logic        sz32;
        logic [15:0] addr;
        logic [15:0] data;
        logic [31:0] exp;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 1'b0, 16'h0002, 16'hA5A5, 32'h0},
        '{1'b0, 1'b0, 16'h0002, 16'h0000, 32'h0000A5A5},
        '{1'b0, 1'b0, 16'h0042, 16'h0000, 32'h0000A5A5},
        '{1'b0, 1'b0, 16'h0006, 16'h0000, 32'h0},
        '{1'b0, 1'b1, 16'h0002, 16'h0000, 32'h0},
        '{1'b1, 1'b0, 16'h0004, 16'h0C03, 32'h0},
        '{1'b0, 1'b0, 16'h0004, 16'h0000, 32'h00000C03},
        '{1'b0, 1'b1, 16'h0008, 16'h0000, 32'h0},
        '{1'b1, 1'b1, 16'h0002, 16'h1111, 32'h0},
        '{1'b0, 1'b0, 16'h0002, 16'h0000, 32'h0000A5A5},
        '{1'b1, 1'b0, 16'h0002, 16'h0000, 32'h0}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [15:0] d, input logic sz);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_size32 = sz;
        @(negedge clk);
        bus_wr = 1'b0; bus_size32 = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, input logic sz, output logic [31:0] d);
        bus_rd = 1'b1; bus_addr = a; bus_size32 = sz;
        #1 d = bus_rdata;
        bus_rd = 1'b0; bus_size32 = 1'b0;
    endtask

    task automatic tick(input int n);
        @(negedge clk);
        tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic apm(input logic [7:0] b, input logic se);
        @(negedge clk);
        apm_wr = 1'b1; apm_data = b; smi_en = se;
        @(negedge clk);
        apm_wr = 1'b0; smi_en = 1'b0;
    endtask

    initial begin
        #(8 * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R14 reset state
        rd(16'h0000, 1'b0, rv); check("R14 status", rv, 0);
        rd(16'h0002, 1'b0, rv); check("R14 enable", rv, 0);
        rd(16'h0004, 1'b0, rv); check("R14 control", rv, 0);
        rd(16'h0008, 1'b1, rv); check("R14 timer", rv, 0);
        check("R14 outputs", {27'd0, sci_irq, shutdown_req, reset_req, s3_mark, smi_pulse}, 0);

        // R1 R2 R8 table
        for (int i = 0; i < NV; i++) begin
            if (VECS[i].wr) begin
                wr(VECS[i].addr, VECS[i].data, VECS[i].sz32);
            end else begin
                @(negedge clk);
                rd(VECS[i].addr, VECS[i].sz32, rv);
                check($sformatf("R1 R2 R8 vector %0d", i), rv, VECS[i].exp);
            end
        end

        // R9 shutdown
        wr(16'h0004, 16'h2000, 1'b0);
        check("R9 shutdown pulse", {31'd0, shutdown_req}, 1);
        check("R9 no reset", {31'd0, reset_req}, 0);
        @(negedge clk);
        check("R9 pulse ends", {31'd0, shutdown_req}, 0);
        rd(16'h0004, 1'b0, rv); check("R8 sleep bit dropped", rv, 0);

        // R10 resume
        wr(16'h0004, 16'h2400, 1'b0);
        check("R10 reset and s3", {30'd0, reset_req, s3_mark}, 3);
        rd(16'h0000, 1'b0, rv); check("R10 status set", rv, 32'h8100);
        @(negedge clk);
        check("R10 pulses end", {30'd0, reset_req, s3_mark}, 0);
        rd(16'h0004, 1'b0, rv); check("R8 control", rv, 32'h0400);
        wr(16'h0004, 16'h2C00, 1'b0);
        check("R10 type3 no pulse", {29'd0, shutdown_req, reset_req, s3_mark}, 0);
        rd(16'h0000, 1'b0, rv); check("R10 type3 status", rv, 32'h8100);

        // R7 SCI masking, R3 write-one-to-clear
        wr(16'h0002, 16'h8000, 1'b0);
        check("R7 wake not a source", {31'd0, sci_irq}, 0);
        wr(16'h0002, 16'h0100, 1'b0);
        check("R7 power button source", {31'd0, sci_irq}, 1);
        wr(16'h0000, 16'h0000, 1'b0);
        rd(16'h0000, 1'b0, rv); check("R3 zero write keeps", rv, 32'h8100);
        wr(16'h0000, 16'h0100, 1'b0);
        rd(16'h0000, 1'b0, rv); check("R3 one clears", rv, 32'h8000);
        check("R7 sci drops", {31'd0, sci_irq}, 0);
        wr(16'h0000, 16'hFFFF, 1'b0);

        // R13 power button
        wr(16'h0002, 16'h0000, 1'b0);
        @(negedge clk); pwrbtn_evt = 1'b1; @(negedge clk); pwrbtn_evt = 1'b0;
        rd(16'h0000, 1'b0, rv); check("R13 disabled ignored", rv, 0);
        wr(16'h0002, 16'h0100, 1'b0);
        @(negedge clk); pwrbtn_evt = 1'b1; @(negedge clk); pwrbtn_evt = 1'b0;
        rd(16'h0000, 1'b0, rv); check("R13 enabled sets", rv, 32'h0100);
        check("R13 sci", {31'd0, sci_irq}, 1);
        wr(16'h0000, 16'hFFFF, 1'b0);

        // R11 R12 firmware commands
        apm(8'hF1, 1'b1);
        check("R12 smi pulse", {31'd0, smi_pulse}, 1);
        rd(16'h0004, 1'b0, rv); check("R11 sci on", rv, 32'h0C01);
        @(negedge clk);
        check("R12 smi ends", {31'd0, smi_pulse}, 0);
        apm(8'h55, 1'b0);
        check("R12 no smi when disabled", {31'd0, smi_pulse}, 0);
        rd(16'h0004, 1'b0, rv); check("R11 other byte ignored", rv, 32'h0C01);
        apm(8'hF0, 1'b0);
        rd(16'h0004, 1'b0, rv); check("R11 sci off", rv, 32'h0C00);

        // R4 R5 R6 timer
        wr(16'h0002, 16'h0001, 1'b0);
        tick(127);
        rd(16'h0008, 1'b1, rv); check("R4 timer count", rv, 32'h7F);
        @(negedge clk);
        rd(16'h0000, 1'b0, rv); check("R5 below boundary", rv, 0);
        tick(1);
        @(negedge clk);
        rd(16'h0000, 1'b0, rv); check("R5 boundary reached", rv, 1);
        check("R7 timer sci", {31'd0, sci_irq}, 1);
        wr(16'h0000, 16'h0001, 1'b0);
        @(negedge clk);
        rd(16'h0000, 1'b0, rv); check("R6 cleared and rearmed", rv, 0);
        rd(16'h0008, 1'b1, rv); check("R4 timer 0x80", rv, 32'h80);
        tick(127);
        @(negedge clk);
        rd(16'h0000, 1'b0, rv); check("R6 before new boundary", rv, 0);
        tick(1);
        @(negedge clk);
        rd(16'h0000, 1'b0, rv); check("R6 new boundary", rv, 1);
        rd(16'h0008, 1'b1, rv); check("R4 timer wraps", rv, 0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule